// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits between a parallel flash bus and the rest of a flash memory model. It watches bus write cycles, follows the unlock prefix that every command must carry, and turns a complete sequence into a one-cycle strobe. The strobes cover return to read array, autoselect entry, program, rejected program, chip erase, sector erase, erase suspend and erase resume. The array, the status bits and the timing of erase work are kept outside. They use these strobes together with the registered operation address and data.

A program strobe carries the new word already merged with the old array contents (`arr_q`), so a program can only clear bits. When autoselect mode is active, the block also supplies the identification and sector-protection read data. A mode input selects word or byte addressing. This input changes the unlock addresses and the autoselect read offsets.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is taken only on the first clock edge where `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold. A cycle with `ce_n`=1 or `oe_n`=0 is ignored. Holding the write condition over several cycles counts as one write.
- R2: A command needs two unlock writes: data AAh at low address 555h, then 55h at 2AAh in word mode (`word_mode`=1), or at AAAh then 555h in byte mode. Only `addr[11:0]` is compared. A write that does not match the expected step returns the decoder to idle.
- R3: After the unlock pair, a write of 90h to the first unlock address raises `stb_autosel` and enters autoselect mode (`autosel_mode`=1).
- R4: In autoselect mode, `rdata` depends on `addr[7:0]`. In word mode: 00h gives 00C2h, 01h gives DEV_ID, and 02h gives the protect bit of the addressed sector. In byte mode: 00h gives C2h, 02h gives DEV_ID[7:0], and 04h gives the protect bit. Any other offset, and any read outside the mode, gives 0. While the mode is active, writes other than F0h have no effect.
- R5: A write of A0h after the unlock pair arms a program. The next write raises `stb_prog`, with `op_addr` equal to its address and `op_data` equal to `arr_q & wdata`.
- R6: When the program write targets a protected sector, `stb_prog_rej` is raised instead of `stb_prog`. The sector index is `addr[ADDR_W-1 -: SECT_W]`, and the sector is protected when its bit in `sect_prot` is 1.
- R7: The sequence unlock, 80h, unlock, then 10h at the first unlock address raises `stb_chip_erase`. A wrong step anywhere in the sequence yields no strobe.
- R8: The sequence unlock, 80h, unlock, then 30h at any address raises `stb_sect_erase`, with `op_addr` set to that address.
- R9: F0h at any address, when `op_busy`=0, raises `stb_reset` and returns the decoder to idle. This holds from any sequence step and from autoselect mode. While `op_busy`=1, every write except B0h is ignored.
- R10: B0h raises `stb_suspend` when the decoder is idle or when `op_busy`=1. 30h in the idle state with `op_busy`=0 raises `stb_resume`.
- R11: Every strobe is high for exactly one cycle, in the cycle after the edge that took the write. At most one strobe is high at a time. After reset, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = word addressing, 0 = byte addressing |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| arr_q | input | DATA_W | Current array contents at `addr` |
| sect_prot | input | 2**SECT_W | Protection bit per sector |
| op_busy | input | 1 | An embedded program or erase is running |
| stb_reset | output | 1 | Return-to-read-array strobe |
| stb_autosel | output | 1 | Autoselect entry strobe |
| stb_prog | output | 1 | Program strobe |
| stb_prog_rej | output | 1 | Program to a protected sector |
| stb_chip_erase | output | 1 | Chip erase strobe |
| stb_sect_erase | output | 1 | Sector erase strobe |
| stb_suspend | output | 1 | Erase suspend strobe |
| stb_resume | output | 1 | Erase resume strobe |
| op_addr | output | ADDR_W | Address of the last accepted write |
| op_data | output | DATA_W | Merged program data of the last accepted write |
| autosel_mode | output | 1 | Autoselect mode active |
| rdata | output | DATA_W | Autoselect read data |

## Verification
The sequence state cannot be seen directly. A wrong state shows up at the ports one cycle after the final write of a sequence, either as a missing strobe or as the wrong strobe. For autoselect, it shows up at once on `rdata` and `autosel_mode`. The bench sweeps every third-cycle command byte in both addressing modes and follows each one with F0h. An unexpected arm therefore appears both on that write and on the reset that follows. Every offset and sector of the autoselect read space is also read in both modes. A detector that mis-qualifies writes shows up as a lost step or a doubled strobe on the following command.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command codes for the flash command decoder.
// Assumes command codes sit in the low byte of the write data.
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_PROG,
        S_ESET,
        S_EUNL1,
        S_EUNL2,
        S_AUTO
    } seq_state_t;

    // Strobe bundle, one bit per command outcome.
    typedef struct packed {
        logic reset;
        logic autosel;
        logic prog;
        logic prog_rej;
        logic chip;
        logic sect;
        logic susp;
        logic resume;
    } strobe_t;

    localparam logic [7:0] CMD_UNLK_A   = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B   = 8'h55;
    localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECT     = 8'h30;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_READ     = 8'hF0;
    localparam logic [7:0] MFR_CODE     = 8'hC2;

    // First unlock address for the selected addressing mode.
    function automatic logic [11:0] unlock_a_addr(input logic word);
        return word ? 12'h555 : 12'hAAA;
    endfunction

    // Second unlock address for the selected addressing mode.
    function automatic logic [11:0] unlock_b_addr(input logic word);
        return word ? 12'h2AA : 12'h555;
    endfunction

endpackage

// File: rtl/fcd_wr_detect.sv
// Write-cycle qualifier: produces a one-cycle pulse on the first clock
// where chip enable and write enable are active and output enable is not.
// Assumes the bus inputs are already synchronous to clk.
module fcd_wr_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_fire
);
    logic wr_cond;
    logic wr_prev;

    // Qualify the bus state as a write.
    always_comb wr_cond = !ce_n && !we_n && oe_n;

    // Remember the previous write condition for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b1;
        else        wr_prev <= wr_cond;
    end

    // Fire only when the condition newly appears.
    always_comb wr_fire = wr_cond && !wr_prev;

    p_single_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

endmodule

// File: rtl/fcd_seq_fsm.sv
// Command sequence tracker. Follows the unlock prefix and the command
// cycles and registers one strobe per completed command, along with the
// operation address and the merged program data.
// Assumes wr_fire is a single-cycle pulse that is valid with addr and wdata.
module fcd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_q,
    input  logic [NSECT-1:0]  sect_prot,
    input  logic              op_busy,
    output strobe_t           stb,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              autosel_mode
);
    seq_state_t state, nxt_state;
    strobe_t    nxt_stb;
    logic [7:0] cmd;
    logic       at_a, at_b, prot_hit;

    // Decode the command byte, unlock-address matches and sector protection.
    always_comb begin
        cmd      = wdata[7:0];
        at_a     = addr[11:0] == unlock_a_addr(word_mode);
        at_b     = addr[11:0] == unlock_b_addr(word_mode);
        prot_hit = sect_prot[addr[ADDR_W-1 -: SECT_W]];
    end

    // Work out the next sequence step and the strobe for this write.
    always_comb begin
        nxt_state = state;
        nxt_stb   = '0;
        if (wr_fire) begin
            if (op_busy) begin
                nxt_stb.susp = (cmd == CMD_SUSPEND);
            end else if (cmd == CMD_READ) begin
                nxt_stb.reset = 1'b1;
                nxt_state     = S_IDLE;
            end else begin
                nxt_state = S_IDLE;
                unique case (state)
                    S_IDLE: begin
                        if (cmd == CMD_UNLK_A && at_a) nxt_state = S_UNL1;
                        nxt_stb.susp   = (cmd == CMD_SUSPEND);
                        nxt_stb.resume = (cmd == CMD_SECT);
                    end
                    S_UNL1: if (cmd == CMD_UNLK_B && at_b) nxt_state = S_UNL2;
                    S_UNL2: if (at_a) begin
                        if (cmd == CMD_AUTOSEL) begin
                            nxt_state       = S_AUTO;
                            nxt_stb.autosel = 1'b1;
                        end else if (cmd == CMD_PROGRAM) begin
                            nxt_state = S_PROG;
                        end else if (cmd == CMD_ERASE) begin
                            nxt_state = S_ESET;
                        end
                    end
                    S_PROG: begin
                        nxt_stb.prog     = !prot_hit;
                        nxt_stb.prog_rej = prot_hit;
                    end
                    S_ESET:  if (cmd == CMD_UNLK_A && at_a) nxt_state = S_EUNL1;
                    S_EUNL1: if (cmd == CMD_UNLK_B && at_b) nxt_state = S_EUNL2;
                    S_EUNL2: begin
                        nxt_stb.chip = (cmd == CMD_CHIP) && at_a;
                        nxt_stb.sect = (cmd == CMD_SECT);
                    end
                    S_AUTO:  nxt_state = S_AUTO;
                    default: nxt_state = S_IDLE;
                endcase
            end
        end
    end

    // Register the state, strobes and operation payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            stb     <= '0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            state <= nxt_state;
            stb   <= nxt_stb;
            if (wr_fire && !op_busy) begin
                op_addr <= addr;
                op_data <= arr_q & wdata;
            end
        end
    end

    // Expose autoselect mode to the read path.
    always_comb autosel_mode = (state == S_AUTO);

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));
    p_strobe_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != '0) |-> $past(wr_fire));
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.reset || stb.prog || stb.chip || stb.sect || stb.autosel) |-> !$past(op_busy));
    p_prog_unprot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb.prog |-> !$past(prot_hit));
    p_auto_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(autosel_mode) |-> stb.autosel);

endmodule

// File: rtl/fcd_autosel_rd.sv
// Autoselect read data: manufacturer code, device code and per-sector
// protection bit, selected by the low address offset and addressing mode.
// Assumes the read data is only meaningful while autoselect mode is active.
module fcd_autosel_rd
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W = 18,
    parameter int          DATA_W = 16,
    parameter int          SECT_W = 3,
    parameter logic [15:0] DEV_ID = 16'h22AB,
    localparam int         NSECT  = 1 << SECT_W
) (
    input  logic              autosel_mode,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSECT-1:0]  sect_prot,
    output logic [DATA_W-1:0] rdata
);
    logic [7:0] ofs;
    logic       prot;

    // Select the identification or protection value for this offset.
    always_comb begin
        ofs   = addr[7:0];
        prot  = sect_prot[addr[ADDR_W-1 -: SECT_W]];
        rdata = '0;
        if (autosel_mode) begin
            if (word_mode) begin
                unique case (ofs)
                    8'h00:   rdata[7:0]  = MFR_CODE;
                    8'h01:   rdata[15:0] = DEV_ID;
                    8'h02:   rdata[0]    = prot;
                    default: rdata       = '0;
                endcase
            end else begin
                unique case (ofs)
                    8'h00:   rdata[7:0] = MFR_CODE;
                    8'h02:   rdata[7:0] = DEV_ID[7:0];
                    8'h04:   rdata[0]   = prot;
                    default: rdata      = '0;
                endcase
            end
        end
    end

    always_comb begin
        if (!autosel_mode) p_quiet_outside_r4: assert (rdata == '0);
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: write qualification, sequence
// tracking and the autoselect read path.
// Assumes all bus inputs are synchronous to clk.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W = 18,
    parameter int          DATA_W = 16,
    parameter int          SECT_W = 3,
    parameter logic [15:0] DEV_ID = 16'h22AB,
    localparam int         NSECT  = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_q,
    input  logic [NSECT-1:0]  sect_prot,
    input  logic              op_busy,
    output logic              stb_reset,
    output logic              stb_autosel,
    output logic              stb_prog,
    output logic              stb_prog_rej,
    output logic              stb_chip_erase,
    output logic              stb_sect_erase,
    output logic              stb_suspend,
    output logic              stb_resume,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              autosel_mode,
    output logic [DATA_W-1:0] rdata
);
    logic    wr_fire;
    strobe_t stb;

    fcd_wr_detect u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .wr_fire (wr_fire)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_fire      (wr_fire),
        .word_mode    (word_mode),
        .addr         (addr),
        .wdata        (wdata),
        .arr_q        (arr_q),
        .sect_prot    (sect_prot),
        .op_busy      (op_busy),
        .stb          (stb),
        .op_addr      (op_addr),
        .op_data      (op_data),
        .autosel_mode (autosel_mode)
    );

    fcd_autosel_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
                     .DEV_ID(DEV_ID)) u_rd (
        .autosel_mode (autosel_mode),
        .word_mode    (word_mode),
        .addr         (addr),
        .sect_prot    (sect_prot),
        .rdata        (rdata)
    );

    // Fan the strobe bundle out to named ports.
    always_comb begin
        stb_reset      = stb.reset;
        stb_autosel    = stb.autosel;
        stb_prog       = stb.prog;
        stb_prog_rej   = stb.prog_rej;
        stb_chip_erase = stb.chip;
        stb_sect_erase = stb.sect;
        stb_suspend    = stb.susp;
        stb_resume     = stb.resume;
    end

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam logic [15:0] DEV = 16'h22AB;
    // Strobe vector bit order: reset autosel prog rej chip sect susp resume
    localparam logic [7:0] V_RST = 8'h80, V_AUTO = 8'h40, V_PROG = 8'h20,
                           V_REJ = 8'h10, V_CHIP = 8'h08, V_SECT = 8'h04,
                           V_SUSP = 8'h02, V_RES = 8'h01, V_NONE = 8'h00;

    logic clk = 0, rst_n = 0;
    logic ce_n = 1, we_n = 1, oe_n = 1, word_mode = 1, op_busy = 0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0, arr_q = '0;
    logic [7:0] sect_prot = 8'b0101_0011;
    logic stb_reset, stb_autosel, stb_prog, stb_prog_rej, stb_chip_erase;
    logic stb_sect_erase, stb_suspend, stb_resume, autosel_mode;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data, rdata;

    int checks = 0, failures = 0, cyc = 0;
    logic [7:0] s_vec, s_post;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;

    always #10 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .word_mode(word_mode), .addr(addr), .wdata(wdata), .arr_q(arr_q),
        .sect_prot(sect_prot), .op_busy(op_busy),
        .stb_reset(stb_reset), .stb_autosel(stb_autosel), .stb_prog(stb_prog),
        .stb_prog_rej(stb_prog_rej), .stb_chip_erase(stb_chip_erase),
        .stb_sect_erase(stb_sect_erase), .stb_suspend(stb_suspend),
        .stb_resume(stb_resume), .op_addr(op_addr), .op_data(op_data),
        .autosel_mode(autosel_mode), .rdata(rdata)
    );

    function automatic logic [7:0] vec();
        return {stb_reset, stb_autosel, stb_prog, stb_prog_rej,
                stb_chip_erase, stb_sect_erase, stb_suspend, stb_resume};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write cycle; capture strobes one edge after the write and one more.
    task automatic wr_bus(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic c, input logic o);
        @(negedge clk);
        addr = a; wdata = d; ce_n = c; we_n = 0; oe_n = o;
        @(negedge clk);
        s_vec = vec(); s_addr = op_addr; s_data = op_data;
        we_n = 1; ce_n = 1; oe_n = 1;
        @(negedge clk);
        s_post = vec();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        wr_bus(a, d, 1'b0, 1'b1);
    endtask

    function automatic logic [AW-1:0] ua(input logic w);
        return w ? 18'h555 : 18'hAAA;
    endfunction
    function automatic logic [AW-1:0] ub(input logic w);
        return w ? 18'h2AA : 18'h555;
    endfunction

    task automatic unlock();
        wr(ua(word_mode), 16'hAA);
        wr(ub(word_mode), 16'h55);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] expv;
        logic [15:0] expd;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk(vec() == 0, "R11 reset strobes", vec(), 0);
        chk(autosel_mode == 0 && rdata == 0, "R4 reset mode", rdata, 0);

        // R3/R9/R2: sweep of every third-cycle command in both modes
        for (int m = 0; m < 2; m++) begin
            word_mode = m[0];
            for (int c = 0; c < 256; c++) begin
                unlock();
                wr(ua(word_mode), 16'(c));
                expv = (c == 8'h90) ? V_AUTO : (c == 8'hF0) ? V_RST : V_NONE;
                chk(s_vec == expv, "R3 third-cycle sweep", s_vec, expv);
                wr(18'h3_1234, 16'hF0);
                chk(s_vec == V_RST, "R9 reset after sweep", s_vec, V_RST);
            end
        end

        // R2: wrong-mode unlock addresses
        word_mode = 1;
        wr(18'hAAA, 16'hAA); wr(18'h2AA, 16'h55); wr(18'h555, 16'h90);
        chk(s_vec == 0 && !autosel_mode, "R2 word mode bad addr", s_vec, 0);
        word_mode = 0;
        wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55); wr(18'h555, 16'h90);
        chk(s_vec == 0 && !autosel_mode, "R2 byte mode bad addr", s_vec, 0);
        word_mode = 1;
        wr(18'h555, 16'hAA); wr(18'h2AA, 16'h56); wr(18'h555, 16'h90);
        chk(s_vec == 0 && !autosel_mode, "R2 bad unlock data", s_vec, 0);
        // upper address bits are don't-care
        wr(18'h3_F555, 16'hAA); wr(18'h2_02AA, 16'h55); wr(18'h1_0555, 16'h90);
        chk(s_vec == V_AUTO, "R2 upper bits ignored", s_vec, V_AUTO);
        wr(0, 16'hF0);

        // R1: disqualified cycles
        wr_bus(18'h555, 16'hAA, 1'b0, 1'b0);
        wr(18'h2AA, 16'h55); wr(18'h555, 16'h90);
        chk(s_vec == 0, "R1 oe_n low ignored", s_vec, 0);
        wr(18'h555, 16'hAA);
        wr_bus(18'h2AA, 16'h55, 1'b1, 1'b1);
        wr(18'h555, 16'h90);
        chk(s_vec == 0, "R1 ce_n high ignored", s_vec, 0);
        // held write counts once
        unlock();
        @(negedge clk);
        addr = 18'h555; wdata = 16'h90; ce_n = 0; we_n = 0; oe_n = 1;
        pulses = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (stb_autosel) pulses++;
        end
        we_n = 1; ce_n = 1;
        chk(pulses == 1, "R1 held write single strobe", pulses, 1);
        @(negedge clk);

        // R4: autoselect read sweep, word mode (mode still active)
        for (int m = 1; m >= 0; m--) begin
            word_mode = m[0];
            if (m == 0) begin
                wr(0, 16'hF0);
                unlock(); wr(ua(0), 16'h90);
                chk(s_vec == V_AUTO, "R3 byte autoselect entry", s_vec, V_AUTO);
            end
            for (int s = 0; s < 8; s++) begin
                for (int o = 0; o < 8; o++) begin
                    @(negedge clk);
                    addr = {3'(s), 7'd0, 8'(o)};
                    #1;
                    expd = 0;
                    if (o == 0) expd = 16'h00C2;
                    else if (m == 1 && o == 1) expd = DEV;
                    else if (m == 0 && o == 2) expd = {8'h00, DEV[7:0]};
                    else if ((m == 1 && o == 2) || (m == 0 && o == 4))
                        expd = {15'd0, sect_prot[s]};
                    chk(rdata == expd, "R4 autoselect read", rdata, expd);
                end
            end
            // writes other than F0 ignored in the mode
            wr(ua(word_mode), 16'hAA); wr(ub(word_mode), 16'h55);
            wr(ua(word_mode), 16'hA0); wr(18'h0_0010, 16'h0000);
            chk(s_vec == 0 && autosel_mode, "R4 writes ignored in mode", s_vec, 0);
        end
        wr(0, 16'hF0);
        chk(s_vec == V_RST && !autosel_mode, "R9 exit autoselect", s_vec, V_RST);
        @(negedge clk); addr = 0; #1;
        chk(rdata == 0, "R4 rdata outside mode", rdata, 0);

        // R5: program merges with AND
        word_mode = 1;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] od, nd;
            od = 16'hFFFF ^ (16'(i) * 16'h1111);
            nd = 16'hA5C3 ^ (16'(i) << 3);
            arr_q = od;
            unlock(); wr(ua(1), 16'hA0);
            wr({3'd2, 15'(i * 7)}, nd);
            chk(s_vec == V_PROG, "R5 program strobe", s_vec, V_PROG);
            chk(s_data == (od & nd), "R5 program data", s_data, od & nd);
            chk(s_addr == {3'd2, 15'(i * 7)}, "R5 program addr", s_addr, {3'd2, 15'(i * 7)});
            chk(s_post == 0, "R11 strobe one cycle", s_post, 0);
        end

        // R6: protected sectors reject, sweep all sectors
        for (int s = 0; s < 8; s++) begin
            unlock(); wr(ua(1), 16'hA0);
            wr({3'(s), 15'h0100}, 16'h0000);
            expv = sect_prot[s] ? V_REJ : V_PROG;
            chk(s_vec == expv, "R6 protected program", s_vec, expv);
        end

        // R7: chip erase, both modes; and with a bad fifth step
        for (int m = 0; m < 2; m++) begin
            word_mode = m[0];
            unlock(); wr(ua(word_mode), 16'h80); unlock(); wr(ua(word_mode), 16'h10);
            chk(s_vec == V_CHIP, "R7 chip erase", s_vec, V_CHIP);
            unlock(); wr(ua(word_mode), 16'h80);
            wr(ua(word_mode), 16'hAA); wr(ub(word_mode), 16'h54);
            wr(ua(word_mode), 16'h10);
            chk(s_vec == 0, "R7 bad second unlock", s_vec, 0);
        end

        // R8: sector erase at each sector
        word_mode = 1;
        for (int s = 0; s < 8; s++) begin
            unlock(); wr(ua(1), 16'h80); unlock(); wr({3'(s), 15'h0ABC}, 16'h30);
            chk(s_vec == V_SECT, "R8 sector erase", s_vec, V_SECT);
            chk(s_addr == {3'(s), 15'h0ABC}, "R8 sector addr", s_addr, {3'(s), 15'h0ABC});
        end

        // R9: F0 mid-sequence, and busy blocking
        wr(ua(1), 16'hAA); wr(18'h1234, 16'hF0);
        chk(s_vec == V_RST, "R9 reset mid-sequence", s_vec, V_RST);
        wr(ub(1), 16'h55); wr(ua(1), 16'h90);
        chk(s_vec == 0, "R9 sequence restarted", s_vec, 0);
        op_busy = 1;
        wr(0, 16'hF0);
        chk(s_vec == 0, "R9 reset ignored while busy", s_vec, 0);
        unlock(); wr(ua(1), 16'h90);
        chk(s_vec == 0 && !autosel_mode, "R9 command ignored while busy", s_vec, 0);
        wr(18'h7777, 16'hB0);
        chk(s_vec == V_SUSP, "R10 suspend while busy", s_vec, V_SUSP);
        wr(18'h7777, 16'h30);
        chk(s_vec == 0, "R10 resume ignored while busy", s_vec, 0);
        op_busy = 0;

        // R10: suspend and resume from idle
        wr(18'h2_0000, 16'hB0);
        chk(s_vec == V_SUSP, "R10 suspend idle", s_vec, V_SUSP);
        wr(18'h2_0000, 16'h30);
        chk(s_vec == V_RES, "R10 resume idle", s_vec, V_RES);
        chk(s_post == 0, "R11 resume one cycle", s_post, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule